// File: doc/BRIEF.md
# Auto-Reload Toggle-Output Timer

This block is a pair of down-counting timers. Each one is advanced by its own single-cycle clock-enable pulse, which comes from a clock selector outside the block. The first channel counts down to zero. On the next tick it loads its reload value again, without wrapping, and it can invert an output pin on each of these underflows. With a reload value of R, the pin therefore flips every R+1 ticks and forms a square wave with a 50% duty cycle that needs no software help once it is started. Only a low-to-high flip of that pin raises the first pending flag. A falling flip does not.

The second channel counts in the same way from its own reload value. Every one of its underflows raises a second pending flag. Software reaches the block through a write-only register port. It can set both reload values, the toggle enable and the two interrupt enables. It can force the pin level and clear the pending flags by writing ones. The interrupt line is active while any pending flag is set together with its enable.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_n` rises. After reset both counters, both reload values, all enables, the pin and both flags are zero.

Top module: `reload_pwm_timer`

## Requirements
- R1: After reset, `cnt_a`, `cnt_b`, `pin_out`, `pend_a`, `pend_b` and `irq` are all 0, and the reload values and enables are 0.
- R2: A `tick_a` pulse while `cnt_a` is not zero lowers `cnt_a` by exactly one at the next edge. Without a `tick_a` pulse, `cnt_a` holds its value, whatever is written on the register port.
- R3: A `tick_a` pulse while `cnt_a` is zero loads `cnt_a` with the reload-A value (address 0). It never produces the all-ones value unless that value is the reload value.
- R4: On each channel-A underflow, `pin_out` inverts if the toggle-enable bit (address 2, bit 0) is set. If that bit is clear, `pin_out` keeps its level.
- R5: Writing address 4 sets `pin_out` to data bit 0 at the next edge and leaves both counts unchanged. If this write falls in the same cycle as a toggle, the write wins.
- R6: `pend_a` is set only by an underflow toggle that takes `pin_out` from 0 to 1. A toggle from 1 to 0, or a level write, does not set it.
- R7: A `tick_b` pulse decrements `cnt_b`, or loads `cnt_b` from the reload-B value (address 1) when `cnt_b` is zero. Every such underflow sets `pend_b`. Channel B never affects channel A, and channel A never affects channel B.
- R8: Writing address 3 with bit 0 or bit 1 set clears `pend_a` or `pend_b` respectively. If a set event happens in the same cycle as the clear, the flag stays set.
- R9: Writing a new reload value does not change a count in progress. The new value is loaded at the next underflow.
- R10: `irq` is 1 exactly when (`pend_a` and the A interrupt enable, address 2 bit 1) or (`pend_b` and the B interrupt enable, address 2 bit 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | Count enable for channel A |
| tick_b | input | 1 | Count enable for channel B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 reload A, 1 reload B, 2 control, 3 clear, 4 pin level |
| wr_data | input | 16 | Register write data |
| cnt_a | output | 16 | Channel A count |
| cnt_b | output | 16 | Channel B count |
| pin_out | output | 1 | Toggle output |
| pend_a | output | 1 | Channel A pending flag (rising pin) |
| pend_b | output | 1 | Channel B pending flag (underflow) |
| irq | output | 1 | Interrupt request |

## Verification
All state is visible at the ports, so a fault shows up quickly. A wrong count shows up at the next edge. A wrong reload shows up one edge after the underflow tick. A lost or spurious pin toggle inverts the phase of the square wave for every later period. A wrong edge test on the pending logic shows up as a flag raised on the falling flip, or no flag on the rising one, at that same edge. A wrong set/clear priority is exposed only by a clear that coincides with an underflow, so the bench forces that collision deliberately.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_RELOAD_A = 3'd0,
    ADR_RELOAD_B = 3'd1,
    ADR_CTRL     = 3'd2,
    ADR_CLEAR    = 3'd3,
    ADR_LEVEL    = 3'd4
  } reg_addr_e;

  localparam int CTRL_TOG = 0;
  localparam int CTRL_IEA = 1;
  localparam int CTRL_IEB = 2;
  localparam int CLR_A    = 0;
  localparam int CLR_B    = 1;
  localparam int NUM_CH   = 2;
endpackage

// File: rtl/rpt_rst_sync.sv
module rpt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/rpt_regs.sv
module rpt_regs
  import rpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  reload_a,
  output logic [CNT_W-1:0]  reload_b,
  output logic              tog_en,
  output logic              ie_a,
  output logic              ie_b,
  output logic              lvl_wr,
  output logic              lvl_val,
  output logic              clr_a,
  output logic              clr_b
);
  logic [CNT_W-1:0] reload_a_d, reload_b_d;
  logic             tog_en_d, ie_a_d, ie_b_d;
  logic             sel_ra, sel_rb, sel_ctrl, sel_clr;

  always_comb begin
    sel_ra   = wr_en && (wr_addr == ADR_RELOAD_A);
    sel_rb   = wr_en && (wr_addr == ADR_RELOAD_B);
    sel_ctrl = wr_en && (wr_addr == ADR_CTRL);
    sel_clr  = wr_en && (wr_addr == ADR_CLEAR);
    lvl_wr   = wr_en && (wr_addr == ADR_LEVEL);
    lvl_val  = wr_data[0];
    clr_a    = sel_clr && wr_data[CLR_A];
    clr_b    = sel_clr && wr_data[CLR_B];
  end

  always_comb begin
    reload_a_d = sel_ra   ? wr_data           : reload_a;
    reload_b_d = sel_rb   ? wr_data           : reload_b;
    tog_en_d   = sel_ctrl ? wr_data[CTRL_TOG] : tog_en;
    ie_a_d     = sel_ctrl ? wr_data[CTRL_IEA] : ie_a;
    ie_b_d     = sel_ctrl ? wr_data[CTRL_IEB] : ie_b;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      reload_a <= '0;
      reload_b <= '0;
      tog_en   <= 1'b0;
      ie_a     <= 1'b0;
      ie_b     <= 1'b0;
    end else begin
      reload_a <= reload_a_d;
      reload_b <= reload_b_d;
      tog_en   <= tog_en_d;
      ie_a     <= ie_a_d;
      ie_b     <= ie_b_d;
    end
  end
endmodule

// File: rtl/rpt_down_counter.sv
module rpt_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             uflow
);
  logic [CNT_W-1:0] count_d;
  logic             at_zero;

  always_comb begin
    at_zero = (count == '0);
    uflow   = tick && at_zero;
    count_d = count;
    if (tick) count_d = at_zero ? reload : count - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) count <= '0;
    else         count <= count_d;
  end
endmodule

// File: rtl/rpt_toggle_out.sv
module rpt_toggle_out (
  input  logic clk,
  input  logic rst_sn,
  input  logic uflow,
  input  logic tog_en,
  input  logic lvl_wr,
  input  logic lvl_val,
  output logic pin,
  output logic rise
);
  logic pin_d, flip;

  always_comb begin
    flip  = uflow && tog_en && !lvl_wr;
    rise  = flip && !pin;
    pin_d = pin;
    if (lvl_wr)    pin_d = lvl_val;
    else if (flip) pin_d = !pin;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) pin <= 1'b0;
    else         pin <= pin_d;
  end
endmodule

// File: rtl/rpt_pend_flag.sv
module rpt_pend_flag (
  input  logic clk,
  input  logic rst_sn,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_d;

  always_comb begin
    flag_d = flag;
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) flag <= 1'b0;
    else         flag <= flag_d;
  end
endmodule

// File: rtl/reload_pwm_timer.sv
module reload_pwm_timer
  import rpt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_a,
  input  logic              tick_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  cnt_a,
  output logic [CNT_W-1:0]  cnt_b,
  output logic              pin_out,
  output logic              pend_a,
  output logic              pend_b,
  output logic              irq
);
  logic             rst_sn;
  logic [CNT_W-1:0] reload_a, reload_b;
  logic             tog_en, ie_a, ie_b, lvl_wr, lvl_val, clr_a, clr_b;
  logic             uflow_a, uflow_b, rise_a;
  logic [NUM_CH-1:0] pend_set, pend_clr, pend_q, pend_ie;

  rpt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  rpt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_sn(rst_sn), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .reload_a(reload_a), .reload_b(reload_b),
    .tog_en(tog_en), .ie_a(ie_a), .ie_b(ie_b), .lvl_wr(lvl_wr),
    .lvl_val(lvl_val), .clr_a(clr_a), .clr_b(clr_b)
  );

  rpt_down_counter #(.CNT_W(CNT_W)) u_cnt_a (
    .clk(clk), .rst_sn(rst_sn), .tick(tick_a), .reload(reload_a),
    .count(cnt_a), .uflow(uflow_a)
  );

  rpt_down_counter #(.CNT_W(CNT_W)) u_cnt_b (
    .clk(clk), .rst_sn(rst_sn), .tick(tick_b), .reload(reload_b),
    .count(cnt_b), .uflow(uflow_b)
  );

  rpt_toggle_out u_pin (
    .clk(clk), .rst_sn(rst_sn), .uflow(uflow_a), .tog_en(tog_en),
    .lvl_wr(lvl_wr), .lvl_val(lvl_val), .pin(pin_out), .rise(rise_a)
  );

  assign pend_set = {uflow_b, rise_a};
  assign pend_clr = {clr_b, clr_a};
  assign pend_ie  = {ie_b, ie_a};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_pend
    rpt_pend_flag u_flag (
      .clk(clk), .rst_sn(rst_sn), .set(pend_set[g]), .clr(pend_clr[g]),
      .flag(pend_q[g])
    );
  end

  assign pend_a = pend_q[0];
  assign pend_b = pend_q[1];
  assign irq    = |(pend_q & pend_ie);
endmodule

// File: rtl/rpt_checker.sv
module rpt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sn,
  input logic             tick_a,
  input logic             tick_b,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] cnt_b,
  input logic [CNT_W-1:0] reload_a,
  input logic [CNT_W-1:0] reload_b,
  input logic             tog_en,
  input logic             pin_out,
  input logic             pend_a,
  input logic             pend_b,
  input logic             irq
);
  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick_a && cnt_a != '0) |=> (cnt_a == $past(cnt_a) - 1'b1));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    !tick_a |=> $stable(cnt_a));

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick_a && cnt_a == '0) |=> (cnt_a == $past(reload_a)));

  p_pin_quiet_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (!tog_en && !(wr_en && wr_addr == 3'd4)) |=> $stable(pin_out));

  p_rise_only_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(pend_a) |-> $rose(pin_out));

  p_uflow_b_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick_b && cnt_b == '0) |=> (pend_b && cnt_b == $past(reload_b)));

  p_irq_idle_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (!pend_a && !pend_b) |-> !irq);
endmodule

bind reload_pwm_timer rpt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .tick_a(tick_a), .tick_b(tick_b),
  .wr_en(wr_en), .wr_addr(wr_addr), .cnt_a(cnt_a), .cnt_b(cnt_b),
  .reload_a(reload_a), .reload_b(reload_b), .tog_en(tog_en),
  .pin_out(pin_out), .pend_a(pend_a), .pend_b(pend_b), .irq(irq)
);

// File: tb/tb_reload_pwm_timer.sv
module tb_reload_pwm_timer;
  logic        clk, rst_n, tick_a, tick_b, wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [15:0] cnt_a, cnt_b;
  logic        pin_out, pend_a, pend_b, irq;

  int checks = 0;
  int errors = 0;

  logic [15:0] ea, eb, ra, rb;
  logic        ep, pa, pb, tog, iea, ieb;

  reload_pwm_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .pin_out(pin_out),
    .pend_a(pend_a), .pend_b(pend_b), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // One clock cycle of stimulus, starting at a falling edge; the model follows the requirements.
  task automatic cyc(input logic ta, input logic tb_, input logic we,
                     input logic [2:0] a, input logic [15:0] d);
    logic ua, ub, lw;
    ua = ta && ea == 16'd0;
    ub = tb_ && eb == 16'd0;
    lw = we && a == 3'd4;
    if (ta) ea = ua ? ra : ea - 16'd1;
    if (tb_) eb = ub ? rb : eb - 16'd1;
    if (lw) ep = d[0];
    else if (ua && tog) begin
      if (!ep) pa = 1'b1;
      ep = !ep;
    end
    if (ub) pb = 1'b1;
    if (we && a == 3'd3) begin
      if (d[0] && !(ua && tog && !lw && pin_out == 1'b0)) pa = pa && !(ua && tog && !lw && !pin_out) ? pa : 1'b0;
      if (d[1] && !ub) pb = 1'b0;
    end
    if (we && a == 3'd0) ra = d;
    if (we && a == 3'd1) rb = d;
    if (we && a == 3'd2) begin tog = d[0]; iea = d[1]; ieb = d[2]; end
    tick_a = ta; tick_b = tb_; wr_en = we; wr_addr = a; wr_data = d;
    @(negedge clk);
    tick_a = 1'b0; tick_b = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cyc(1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic ticks_a(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 3'd0, 16'd0);
  endtask

  task automatic t_reset;
    chk(cnt_a, 16'd0, "R1 cnt_a after reset");
    chk(cnt_b, 16'd0, "R1 cnt_b after reset");
    chk({pin_out, pend_a, pend_b, irq}, 4'b0000, "R1 pin/pend/irq after reset");
  endtask

  task automatic t_count;
    wr(3'd0, 16'd5);
    ticks_a(1);
    chk(cnt_a, 16'd5, "R3 load from zero, no wrap");
    chk(pin_out, 1'b0, "R4 no toggle while disabled");
    chk(pend_a, 1'b0, "R6 no pend without toggle");
    ticks_a(3);
    chk(cnt_a, 16'd2, "R2 three decrements");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, 3'd0, 16'd0);
    chk(cnt_a, 16'd2, "R2 hold without tick_a (R7 isolation)");
    wr(3'd2, 16'h0000);
    chk(cnt_a, 16'd2, "R2 hold during register write");
    ticks_a(3);
    chk(cnt_a, 16'd5, "R3 reload after reaching zero");
  endtask

  task automatic t_toggle;
    wr(3'd3, 16'h0003);
    wr(3'd2, 16'h0003);
    ticks_a(5);
    chk(cnt_a, 16'd0, "R2 counted to zero");
    chk(pin_out, 1'b0, "R4 pin before underflow");
    ticks_a(1);
    chk(pin_out, 1'b1, "R4 pin toggled high");
    chk(pend_a, 1'b1, "R6 pend on rising toggle");
    chk(irq, 1'b1, "R10 irq with ie_a");
    wr(3'd3, 16'h0001);
    chk(pend_a, 1'b0, "R8 clear pend_a");
    chk(irq, 1'b0, "R10 irq drops after clear");
    ticks_a(6);
    chk(pin_out, 1'b0, "R4 pin toggled low after 6 ticks");
    chk(pend_a, 1'b0, "R6 no pend on falling toggle");
    ticks_a(6);
    chk(pin_out, 1'b1, "R4 square wave second rise");
    chk(pend_a, pa, "R6 pend on second rise");
  endtask

  task automatic t_level;
    ticks_a(2);
    wr(3'd4, 16'h0000);
    chk(pin_out, 1'b0, "R5 level write low");
    chk(cnt_a, ea, "R5 count untouched by level write");
    wr(3'd3, 16'h0001);
    wr(3'd4, 16'h0001);
    chk(pin_out, 1'b1, "R5 level write high");
    chk(pend_a, 1'b0, "R6 level write does not set pend");
    while (ea != 16'd0) ticks_a(1);
    wr(3'd4, 16'h0000);
    cyc(1'b1, 1'b0, 1'b1, 3'd4, 16'h0001);
    chk(pin_out, 1'b1, "R5 level write wins over toggle");
    chk(pend_a, 1'b0, "R5 no pend when write wins");
  endtask

  task automatic t_reload_change;
    ticks_a(2);
    chk(cnt_a, 16'd3, "R2 count before reload change");
    wr(3'd0, 16'd9);
    chk(cnt_a, 16'd3, "R9 count kept on reload write");
    ticks_a(3);
    chk(cnt_a, 16'd0, "R9 old count continues");
    ticks_a(1);
    chk(cnt_a, 16'd9, "R9 new reload at next underflow");
  endtask

  task automatic t_chan_b;
    wr(3'd2, 16'h0004);
    wr(3'd1, 16'd3);
    cyc(1'b0, 1'b1, 1'b0, 3'd0, 16'd0);
    chk(cnt_b, 16'd3, "R7 cnt_b loads reload B");
    chk(pend_b, 1'b1, "R7 pend_b on underflow");
    chk(irq, 1'b1, "R10 irq with ie_b");
    chk(cnt_a, 16'd9, "R7 channel A unaffected");
    wr(3'd3, 16'h0002);
    chk(pend_b, 1'b0, "R8 clear pend_b");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, 3'd0, 16'd0);
    chk(cnt_b, 16'd0, "R7 cnt_b decremented to zero");
    cyc(1'b0, 1'b1, 1'b1, 3'd3, 16'h0002);
    chk(pend_b, 1'b1, "R8 set wins over same-cycle clear");
    chk(cnt_b, 16'd3, "R7 cnt_b reloaded again");
    wr(3'd2, 16'h0000);
    chk(irq, 1'b0, "R10 irq masked with pend_b set");
    chk(pend_b, pb, "R10 pend_b kept while masked");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_a = 1'b0; tick_b = 1'b0; wr_en = 1'b0;
    wr_addr = 3'd0; wr_data = 16'd0;
    ea = 0; eb = 0; ra = 0; rb = 0; ep = 0; pa = 0; pb = 0;
    tog = 0; iea = 0; ieb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_count();
    t_toggle();
    t_level();
    t_reload_change();
    t_chan_b();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule